// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block moves outgoing packets from host memory to a link-layer transmitter. Software builds a ring of 16 descriptors, each naming a buffer in memory, its byte count and a flags halfword. It then advances a producer index by a doorbell write. The engine walks the ring from its own consumer index. For each descriptor it reads both descriptor words first, then reads the buffer in 32-bit beats into a local byte FIFO. A packet may be spread over several descriptors; all but the last have the end-of-packet flag clear, and their bytes are joined into one frame.

A frame is offered on the byte stream only once all of its bytes sit in the FIFO. The stream carries start and end markers and obeys a ready handshake. After the last byte has been accepted, the engine writes each descriptor of the packet back to memory with a done bit set. It may then pulse an interrupt line, which is also held in a sticky status bit that software clears by writing 1. Only one memory read and one memory write are outstanding at a time. Each request is held, with a stable address, until its valid or ack returns.

Top module: `txdma_engine`

## Requirements
- R1: After reset, no memory read or write is requested, `tx_valid`, `irq_pulse` and `irq_status` are 0, and `ring_tail` is 0.
- R2: A doorbell write stores `db_idx` as the producer index. No memory read is issued while the producer index equals `ring_tail`. Otherwise the engine processes the slots from `ring_tail` up to, but not including, the producer index, and the indices wrap modulo 16.
- R3: Descriptor slot i sits at RING_BASE + 8*i. The word at offset 0 holds the buffer byte address, whose low two bits are ignored. The word at offset 4 holds the length in bits 15:0 and the flags in bits 31:16. Both words are read, in that order, before any read of that descriptor's buffer.
- R4: Buffer data is read as 32-bit words at ascending word addresses. Byte lane 0 (bits 7:0) comes first, and exactly the descriptor's length in bytes enters the frame.
- R5: Flag bit 0 marks end of packet. The bytes of descriptors without it are followed in the same frame by the bytes of the next descriptors, in ring order. A zero-length descriptor adds no bytes. The end-of-packet descriptor must have a nonzero length.
- R6: `tx_valid` rises only after the whole frame is buffered. `tx_sof` is high on the first byte only and `tx_eof` on the last byte only. While `tx_ready` is low, `tx_valid` and the byte stay unchanged.
- R7: A buffer read is issued only when the FIFO has room for all bytes that beat will supply. A frame of exactly FIFO_DEPTH bytes, assembled from unequal pieces, is delivered whole.
- R8: Only after the last byte of a frame is accepted, each descriptor of that packet, in ring order, gets one 16-bit write of its flags with bit 15 set, to byte address RING_BASE + 8*i + 6.
- R9: If flag bit 1 of the end-of-packet descriptor is set, `irq_pulse` is high for exactly one cycle after the final write-back and `irq_status` becomes 1. Writing `sts_wdata`=0 leaves it set; writing 1 clears it.
- R10: `ring_tail` advances by one as each descriptor is consumed, before the frame completes, and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_idx | input | 4 | Producer index written by the doorbell |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 1 | Status write data, 1 clears the interrupt bit |
| mem_rd_req | output | 1 | Memory read request, held until `mem_rd_valid` |
| mem_rd_addr | output | 32 | Memory read byte address (word aligned) |
| mem_rd_valid | input | 1 | Read data valid, one cycle |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Halfword write request, held until `mem_wr_ack` |
| mem_wr_addr | output | 32 | Halfword write byte address |
| mem_wr_data | output | 16 | Halfword write data |
| mem_wr_ack | input | 1 | Write acknowledge, one cycle |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Stream sink ready |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| irq_status | output | 1 | Sticky interrupt status |
| ring_tail | output | 4 | Hardware consumer index |

## Verification
The hardest state to reach from the ports is a packet left half-posted. The producer index stops inside a chain, so the engine has consumed a non-final descriptor and parked its bytes in the FIFO. The bench posts a lone non-final descriptor, waits, and checks that no byte, write-back or interrupt escapes before the closing descriptor is posted. The FIFO-room rule is reached with a 30-byte piece followed by a 2-byte piece, which leaves two free bytes before the last beat. Ring wrap is reached by posting a run of single-byte packets across slot 15.

// File: rtl/txdma_pkg.sv
`timescale 1ns/1ps
package txdma_pkg;
    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned FLAG_EOP   = 0;
    localparam int unsigned FLAG_IRQ   = 1;
    localparam int unsigned FLAG_DONE  = 15;

    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } tx_byte_t;

    typedef enum logic [2:0] {
        S_IDLE, S_DADDR, S_DLEN, S_DATA_RD, S_PUSH, S_WAIT_TX, S_WB
    } ctrl_state_e;

    function automatic logic [31:0] slot_addr(logic [31:0] base, logic [31:0] idx,
                                              logic [31:0] off);
        return base + idx * DESC_BYTES + off;
    endfunction
endpackage

// File: rtl/txdma_fifo.sv
`timescale 1ns/1ps
module txdma_fifo
    import txdma_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  tx_byte_t   push_data,
    input  logic       pop,
    output tx_byte_t   head,
    output logic       empty,
    output logic [AW:0] free
);
    tx_byte_t        store [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [AW:0]     count;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wptr] <= push_data;
    end

    assign head  = store[rptr];
    assign empty = (count == '0);
    assign free  = (AW+1)'(DEPTH) - count;

    // R7: a push never lands on a full buffer
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        push |-> (free != '0));
    // R6: the stream side never drains an empty buffer
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/txdma_txout.sv
`timescale 1ns/1ps
module txdma_txout
    import txdma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fifo_empty,
    input  tx_byte_t fifo_head,
    input  logic     push_eof,
    output logic     pop,
    output logic     frame_sent,
    output logic     tx_valid,
    output logic [7:0] tx_data,
    output logic     tx_sof,
    output logic     tx_eof,
    input  logic     tx_ready
);
    logic frame_ready;
    logic at_start;

    assign tx_valid   = frame_ready && !fifo_empty;
    assign tx_data    = fifo_head.data;
    assign tx_eof     = fifo_head.eof;
    assign tx_sof     = at_start;
    assign pop        = tx_valid && tx_ready;
    assign frame_sent = pop && fifo_head.eof;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_ready <= 1'b0;
            at_start    <= 1'b1;
        end else begin
            if (push_eof)        frame_ready <= 1'b1;
            else if (frame_sent) frame_ready <= 1'b0;
            if (pop)             at_start <= fifo_head.eof;
        end
    end

    // R6: an offered byte stays put until the sink takes it
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eof)
                                     && $stable(tx_sof)));
endmodule

// File: rtl/txdma_ctrl.sv
`timescale 1ns/1ps
module txdma_ctrl
    import txdma_pkg::*;
#(
    parameter int          RING_ENTRIES = 16,
    parameter logic [31:0] RING_BASE    = 32'h0000_0100,
    parameter int          FREE_W       = 6,
    localparam int         IDX_W        = $clog2(RING_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  head,
    output logic [IDX_W-1:0]  tail,
    output logic              rd_req,
    output logic [31:0]       rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              wr_req,
    output logic [31:0]       wr_addr,
    output logic [15:0]       wr_data,
    input  logic              wr_ack,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              push,
    output tx_byte_t          push_data,
    input  logic              frame_sent,
    output logic              irq_pulse
);
    ctrl_state_e      state;
    logic [IDX_W-1:0] pkt_first, wb_idx;
    logic [31:0]      buf_addr, word;
    logic [15:0]      rem, beat_need;
    logic [1:0]       bi;
    logic             cur_eop, cur_irq;
    logic [15:0]      flag_mem [RING_ENTRIES];

    assign beat_need = (rem >= 16'd4) ? 16'd4 : rem;

    always_comb begin
        rd_req  = 1'b0;
        rd_addr = buf_addr;
        unique case (state)
            S_DADDR:   begin rd_req = 1'b1; rd_addr = slot_addr(RING_BASE, 32'(tail), 32'd0); end
            S_DLEN:    begin rd_req = 1'b1; rd_addr = slot_addr(RING_BASE, 32'(tail), 32'd4); end
            S_DATA_RD: rd_req = (16'(fifo_free) >= beat_need);
            default:   ;
        endcase
    end

    assign wr_req    = (state == S_WB);
    assign wr_addr   = slot_addr(RING_BASE, 32'(wb_idx), 32'd6);
    assign wr_data   = flag_mem[wb_idx] | (16'd1 << FLAG_DONE);
    assign push      = (state == S_PUSH);
    assign push_data = '{eof: cur_eop && (rem == 16'd1), data: word[{bi, 3'b000} +: 8]};

    always_ff @(posedge clk) begin
        if (state == S_DLEN && rd_valid) flag_mem[tail] <= rd_data[31:16];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            tail      <= '0;
            pkt_first <= '0;
            wb_idx    <= '0;
            buf_addr  <= '0;
            word      <= '0;
            rem       <= '0;
            bi        <= '0;
            cur_eop   <= 1'b0;
            cur_irq   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= 1'b0;
            unique case (state)
                S_IDLE: if (tail != head) state <= S_DADDR;
                S_DADDR: if (rd_valid) begin
                    buf_addr <= {rd_data[31:2], 2'b00};
                    state    <= S_DLEN;
                end
                S_DLEN: if (rd_valid) begin
                    rem     <= rd_data[15:0];
                    cur_eop <= rd_data[16 + FLAG_EOP];
                    cur_irq <= rd_data[16 + FLAG_IRQ];
                    if (rd_data[15:0] == 16'd0) begin
                        tail  <= tail + 1'b1;
                        state <= rd_data[16 + FLAG_EOP] ? S_WAIT_TX : S_IDLE;
                    end else begin
                        state <= S_DATA_RD;
                    end
                end
                S_DATA_RD: if (rd_valid) begin
                    word     <= rd_data;
                    buf_addr <= buf_addr + 32'd4;
                    bi       <= '0;
                    state    <= S_PUSH;
                end
                S_PUSH: begin
                    rem <= rem - 16'd1;
                    bi  <= bi + 2'd1;
                    if (rem == 16'd1) begin
                        tail  <= tail + 1'b1;
                        state <= cur_eop ? S_WAIT_TX : S_IDLE;
                    end else if (bi == 2'd3) begin
                        state <= S_DATA_RD;
                    end
                end
                S_WAIT_TX: if (frame_sent) begin
                    wb_idx <= pkt_first;
                    state  <= S_WB;
                end
                S_WB: if (wr_ack) begin
                    if (wb_idx + 1'b1 == tail) begin
                        pkt_first <= tail;
                        irq_pulse <= cur_irq;
                        state     <= S_IDLE;
                    end else begin
                        wb_idx <= wb_idx + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3: a pending read keeps its address until data returns
    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
    // R8: a pending write-back keeps address and data until acknowledged
    assert_wr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
    // R2: an empty ring produces no memory traffic
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && tail == head) |=> !rd_req);
    // R8: reads and write-backs never overlap
    assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));
endmodule

// File: rtl/txdma_engine.sv
`timescale 1ns/1ps
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int          RING_ENTRIES = 16,
    parameter int          FIFO_DEPTH   = 32,
    parameter logic [31:0] RING_BASE    = 32'h0000_0100,
    localparam int         IDX_W        = $clog2(RING_ENTRIES),
    localparam int         FAW          = $clog2(FIFO_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             db_wr,
    input  logic [IDX_W-1:0] db_idx,
    input  logic             sts_wr,
    input  logic             sts_wdata,
    output logic             mem_rd_req,
    output logic [31:0]      mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [31:0]      mem_rd_data,
    output logic             mem_wr_req,
    output logic [31:0]      mem_wr_addr,
    output logic [15:0]      mem_wr_data,
    input  logic             mem_wr_ack,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_sof,
    output logic             tx_eof,
    input  logic             tx_ready,
    output logic             irq_pulse,
    output logic             irq_status,
    output logic [IDX_W-1:0] ring_tail
);
    logic [IDX_W-1:0] head;
    logic             push, pop, fifo_empty, frame_sent;
    tx_byte_t         push_data, fifo_head;
    logic [FAW:0]     fifo_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            head       <= '0;
            irq_status <= 1'b0;
        end else begin
            if (db_wr) head <= db_idx;
            if (irq_pulse)                irq_status <= 1'b1;
            else if (sts_wr && sts_wdata) irq_status <= 1'b0;
        end
    end

    txdma_ctrl #(
        .RING_ENTRIES(RING_ENTRIES), .RING_BASE(RING_BASE), .FREE_W(FAW + 1)
    ) u_ctrl (
        .clk, .rst, .head, .tail(ring_tail),
        .rd_req(mem_rd_req), .rd_addr(mem_rd_addr), .rd_valid(mem_rd_valid),
        .rd_data(mem_rd_data), .wr_req(mem_wr_req), .wr_addr(mem_wr_addr),
        .wr_data(mem_wr_data), .wr_ack(mem_wr_ack), .fifo_free, .push, .push_data,
        .frame_sent, .irq_pulse
    );

    txdma_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk, .rst, .push, .push_data, .pop, .head(fifo_head), .empty(fifo_empty),
        .free(fifo_free)
    );

    txdma_txout u_txout (
        .clk, .rst, .fifo_empty, .fifo_head, .push_eof(push && push_data.eof), .pop,
        .frame_sent, .tx_valid, .tx_data, .tx_sof, .tx_eof, .tx_ready
    );

    // R9: interrupt is a single-cycle pulse and it is latched
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> (!irq_pulse && irq_status));
    // R9: a write of 1 clears status when no new interrupt competes
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && sts_wdata && !irq_pulse) |=> !irq_status);
endmodule

// File: tb/txdma_engine_bench.sv
`timescale 1ns/1ps
module txdma_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        db_wr = 1'b0;
    logic [3:0]  db_idx = '0;
    logic        sts_wr = 1'b0, sts_wdata = 1'b0;
    logic        mem_rd_req, mem_rd_valid;
    logic [31:0] mem_rd_addr, mem_rd_data;
    logic        mem_wr_req, mem_wr_ack;
    logic [31:0] mem_wr_addr;
    logic [15:0] mem_wr_data;
    logic        tx_valid, tx_sof, tx_eof, tx_ready;
    logic [7:0]  tx_data;
    logic        irq_pulse, irq_status;
    logic [3:0]  ring_tail;

    txdma_engine u_txdma_engine (.*);

    initial forever #2.5 clk = ~clk;

    int tests = 0, fails = 0;
    logic [7:0]  bmem [0:1023];
    logic [31:0] rd_log [$];
    logic [31:0] wa_log [$];
    logic [15:0] wd_log [$];
    logic [7:0]  rx_q [$];
    logic        rx_sof [$];
    logic        rx_eof [$];
    logic [7:0]  exp_q [$];
    int  irq_cnt = 0, valid_cycles = 0, lat = 0, sink_cyc = 0;
    bit  bp = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // read responder: data two negedges after a request is seen
    initial begin
        mem_rd_valid = 1'b0; mem_rd_data = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_valid) mem_rd_valid = 1'b0;
            else if (mem_rd_req) begin
                if (lat == 1) begin
                    mem_rd_data  = {bmem[mem_rd_addr[9:0] + 3], bmem[mem_rd_addr[9:0] + 2],
                                    bmem[mem_rd_addr[9:0] + 1], bmem[mem_rd_addr[9:0]]};
                    mem_rd_valid = 1'b1;
                    rd_log.push_back(mem_rd_addr);
                    lat = 0;
                end else lat++;
            end
        end
    end

    // write responder: immediate acknowledge, halfword little-endian
    initial begin
        mem_wr_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_wr_ack) mem_wr_ack = 1'b0;
            else if (mem_wr_req) begin
                mem_wr_ack = 1'b1;
                bmem[mem_wr_addr[9:0]]     = mem_wr_data[7:0];
                bmem[mem_wr_addr[9:0] + 1] = mem_wr_data[15:8];
                wa_log.push_back(mem_wr_addr);
                wd_log.push_back(mem_wr_data);
            end
        end
    end

    // stream sink with optional backpressure, plus interrupt counter
    initial begin
        tx_ready = 1'b1;
        forever begin
            @(negedge clk);
            sink_cyc++;
            tx_ready = !bp || (sink_cyc % 3 != 1);
            if (tx_valid) valid_cycles++;
            if (tx_valid && tx_ready) begin
                rx_q.push_back(tx_data); rx_sof.push_back(tx_sof); rx_eof.push_back(tx_eof);
            end
            if (irq_pulse) irq_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic set_desc(input int slot, input logic [31:0] a, input logic [15:0] len,
                            input logic [15:0] fl);
        int b = 32'h100 + slot * 8;
        for (int k = 0; k < 4; k++) bmem[b + k] = a[8*k +: 8];
        bmem[b + 4] = len[7:0]; bmem[b + 5] = len[15:8];
        bmem[b + 6] = fl[7:0];  bmem[b + 7] = fl[15:8];
    endtask

    task automatic expect_bytes(input int a, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(bmem[(a & ~3) + k]);
    endtask

    task automatic ring(input logic [3:0] idx);
        @(negedge clk); db_wr = 1'b1; db_idx = idx;
        @(negedge clk); db_wr = 1'b0;
    endtask

    task automatic wait_writes(input int n, input string req);
        int k = 0;
        while (wa_log.size() < n && k < 5000) begin @(negedge clk); k++; end
        repeat (4) @(negedge clk);
        check(wa_log.size() == n, req, wa_log.size(), n);
    endtask

    task automatic clear_logs();
        rd_log.delete(); wa_log.delete(); wd_log.delete();
        rx_q.delete(); rx_sof.delete(); rx_eof.delete(); exp_q.delete();
    endtask

    task automatic check_frame(input string req);
        bit ok = (rx_q.size() == exp_q.size());
        for (int k = 0; k < rx_q.size() && ok; k++) begin
            if (rx_q[k] != exp_q[k]) ok = 0;
            if (rx_sof[k] != (k == 0)) ok = 0;
            if (rx_eof[k] != (k == rx_q.size() - 1)) ok = 0;
        end
        check(ok, req, rx_q.size(), exp_q.size());
    endtask

    task automatic t_reset();
        check(!mem_rd_req && !mem_wr_req && !tx_valid, "R1 bus/stream idle",
              {mem_rd_req, mem_wr_req, tx_valid}, 0);
        check(!irq_pulse && !irq_status && ring_tail == 0, "R1 irq/tail",
              {irq_pulse, irq_status, ring_tail}, 0);
    endtask

    task automatic t_idle();
        repeat (20) @(negedge clk);
        check(rd_log.size() == 0, "R2 no reads on empty ring", rd_log.size(), 0);
    endtask

    task automatic t_single();
        clear_logs();
        set_desc(0, 32'h202, 16'd6, 16'h0003);
        expect_bytes(32'h202, 6);
        ring(4'd1);
        wait_writes(1, "R8 one write-back");
        check(rd_log.size() == 4 && rd_log[0] == 32'h100 && rd_log[1] == 32'h104
              && rd_log[2] == 32'h200 && rd_log[3] == 32'h204, "R3 R4 read order",
              rd_log.size() > 2 ? rd_log[2] : 0, 32'h200);
        check_frame("R4 R6 single frame bytes/markers");
        check(wa_log[0] == 32'h106 && wd_log[0] == 16'h8003, "R8 done bit write",
              wd_log[0], 16'h8003);
        check(irq_cnt == 1 && irq_status, "R9 irq pulse and status", irq_cnt, 1);
        check(ring_tail == 4'd1, "R10 tail after one", ring_tail, 1);
    endtask

    task automatic t_status();
        @(negedge clk); sts_wr = 1'b1; sts_wdata = 1'b0;
        @(negedge clk); sts_wr = 1'b0;
        check(irq_status == 1'b1, "R9 write 0 keeps status", irq_status, 1);
        @(negedge clk); sts_wr = 1'b1; sts_wdata = 1'b1;
        @(negedge clk); sts_wr = 1'b0;
        check(irq_status == 1'b0, "R9 write 1 clears status", irq_status, 0);
    endtask

    task automatic t_gather();
        clear_logs(); bp = 1'b1;
        set_desc(1, 32'h240, 16'd5, 16'h0000);
        set_desc(2, 32'h280, 16'd0, 16'h0000);
        set_desc(3, 32'h2C0, 16'd7, 16'h0001);
        expect_bytes(32'h240, 5); expect_bytes(32'h2C0, 7);
        ring(4'd4);
        wait_writes(3, "R8 three write-backs");
        check_frame("R5 R6 gathered frame with backpressure");
        check(wa_log[0] == 32'h10E && wa_log[1] == 32'h116 && wa_log[2] == 32'h11E
              && wd_log[2] == 16'h8001 && wd_log[0] == 16'h8000, "R8 ring-order write-back",
              wa_log[2], 32'h11E);
        check(irq_cnt == 1, "R9 no irq without request flag", irq_cnt, 1);
        bp = 1'b0;
    endtask

    task automatic t_chain_wait();
        clear_logs(); valid_cycles = 0;
        set_desc(4, 32'h300, 16'd3, 16'h0000);
        expect_bytes(32'h300, 3);
        ring(4'd5);
        repeat (60) @(negedge clk);
        check(valid_cycles == 0 && wa_log.size() == 0, "R6 no partial frame offered",
              valid_cycles, 0);
        check(ring_tail == 4'd5, "R10 tail moves before completion", ring_tail, 5);
        set_desc(5, 32'h310, 16'd4, 16'h0003);
        expect_bytes(32'h310, 4);
        ring(4'd6);
        wait_writes(2, "R8 chain write-backs");
        check_frame("R5 frame across late doorbell");
        check(irq_cnt == 2, "R9 irq after chain", irq_cnt, 2);
    endtask

    task automatic t_full();
        clear_logs();
        set_desc(6, 32'h320, 16'd30, 16'h0000);
        set_desc(7, 32'h380, 16'd2, 16'h0001);
        expect_bytes(32'h320, 30); expect_bytes(32'h380, 2);
        ring(4'd8);
        wait_writes(2, "R7 full-buffer write-backs");
        check_frame("R7 frame of FIFO_DEPTH bytes");
    endtask

    task automatic t_wrap();
        bit ok = 1;
        clear_logs();
        for (int k = 0; k < 10; k++) begin
            set_desc((8 + k) % 16, 32'h3A0 + 4 * k, 16'd1, (k == 9) ? 16'h0003 : 16'h0001);
            exp_q.push_back(bmem[32'h3A0 + 4 * k]);
        end
        ring(4'd2);
        wait_writes(10, "R2 ten packets across wrap");
        if (rx_q.size() != 10) ok = 0;
        for (int k = 0; k < rx_q.size() && ok; k++)
            if (rx_q[k] != exp_q[k] || !rx_sof[k] || !rx_eof[k]) ok = 0;
        check(ok, "R2 R6 single-byte frames in ring order", rx_q.size(), 10);
        check(ring_tail == 4'd2 && wa_log[9] == 32'h10E, "R10 tail wraps to 2",
              ring_tail, 2);
        check(irq_cnt == 3, "R9 irq only on requesting packet", irq_cnt, 3);
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) bmem[k] = 8'(k * 13 + 5);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_single();
        t_status();
        t_gather();
        t_chain_wait();
        t_full();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule